// File: doc/BRIEF.md
# Programmable Video Clock Divider

This block derives three clocks from one dot clock: a reference clock that always runs, a shift clock for video memory that stops while the picture is blanked, and a video timing clock for the display controller. All three are taps of a single binary counter that steps on each rising dot-clock edge, so whatever ratios are chosen, their edges stay aligned with each other.

A six-bit select register, written through a one-cycle strobe, sets one ratio for the reference/shift pair and another for the video clock. Each ratio can be a power of two from 1 to 64, and each field has an extra code: it switches the shift clock off, or parks the video clock high. Writing all ones to the register also reloads the counter. Several dividers can be brought into a known phase this way. The block also captures the horizontal sync, vertical sync and blank inputs on the video clock, on the falling edge or on the rising edge.

Top module: `dclk_divider`

## Requirements
- R1: A write (`sel_wr` high at a rising `clk` edge) loads `sel_din` into the select register. Bits [2:0] are the reference/shift code and bits [5:3] are the video code. A code k from 0 to 6 selects division by 2^k.
- R2: `ref_clk` equals `clk` for code 0. For code k ≥ 1 it is the inverse of counter bit k-1. The counter steps by one on every rising edge, so all divided outputs rise together when the counter reaches zero.
- R3: `ref_clk` keeps running while `blank_in` is high. With reference code 7 it runs at division by 64.
- R4: `shift_clk` is `ref_clk` ANDed with a gate. The gate takes the value of NOT `blank_in` only at an edge after which `ref_clk` is low, or at every edge for code 0. The shift clock therefore never pulses while the gate is closed.
- R5: With reference code 7, `shift_clk` is held low.
- R6: `vid_clk` divides like `ref_clk` under its own code. Video code 7 holds it high.
- R7: `hsync_q`, `vsync_q` and `blank_q` take their inputs at the edge where `vid_clk` falls when `vclk_rise` is 0, or where it rises when `vclk_rise` is 1. They take them on every edge for video code 0 and never for video code 7.
- R8: Writing 0x3F sets the counter to all ones. Every divided output is then low until the next edge, at which they all rise.
- R9: Synchronous reset sets the counter to all ones, the select register to 0x38 (reference = dot clock, video held high) and the captured outputs to 0, and closes the shift gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_wr | input | 1 | Select register write strobe |
| sel_din | input | 6 | Select register write data |
| vclk_rise | input | 1 | 1: capture on the video clock rising edge |
| blank_in | input | 1 | Blank input, active high |
| hsync_in | input | 1 | Horizontal sync input |
| vsync_in | input | 1 | Vertical sync input |
| ref_clk | output | 1 | Reference clock |
| shift_clk | output | 1 | Gated shift clock |
| vid_clk | output | 1 | Video timing clock |
| hsync_q | output | 1 | Captured horizontal sync |
| vsync_q | output | 1 | Captured vertical sync |
| blank_q | output | 1 | Captured blank |

## Verification
The counter, the select register, the shift gate and the capture registers all change at a rising dot-clock edge, so every divided output and every capture is due one edge after the stimulus. Only the divide-by-one outputs follow the dot clock level within the same cycle. The bench keeps a model that steps at each rising edge. It drives inputs at the falling edge and compares all outputs 1 ns after each falling edge and 1 ns after each rising edge. In this way both levels of the pass-through clock are seen. Ratio checks count rises over exactly 64 edges after a settling interval, so the count does not depend on the counter phase.

// File: rtl/dclk_pkg.sv
package dclk_pkg;
  localparam int LOG_MAX = 6;
  localparam int CODE_W  = $clog2(LOG_MAX + 2);
  localparam int SEL_W   = 2 * CODE_W;
endpackage

// File: rtl/dclk_counter.sv
module dclk_counter #(
  parameter int W = dclk_pkg::LOG_MAX
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reload,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt
);
  assign cnt_nxt = cnt_q + W'(1);

  // Reload to all ones so every inverted tap starts low.
  always_ff @(posedge clk) begin
    if (rst || reload) cnt_q <= '1;
    else               cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/dclk_tap.sv
module dclk_tap #(
  parameter int LOG_MAX = dclk_pkg::LOG_MAX,
  parameter int CODE_W  = dclk_pkg::CODE_W
) (
  input  logic               clk,
  input  logic [CODE_W-1:0]  code,
  input  logic [LOG_MAX-1:0] cnt,
  input  logic [LOG_MAX-1:0] cnt_nxt,
  output logic               lvl,
  output logic               lvl_nxt,
  output logic               pass,
  output logic               stop
);
  localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(LOG_MAX);

  logic [LOG_MAX:0]  taps;
  logic [LOG_MAX:0]  taps_nxt;
  logic [CODE_W-1:0] idx;

  assign taps[0]     = clk;
  assign taps_nxt[0] = 1'b0;

  for (genvar i = 1; i <= LOG_MAX; i++) begin : g_tap
    assign taps[i]     = ~cnt[i-1];
    assign taps_nxt[i] = ~cnt_nxt[i-1];
  end

  assign idx     = (code > TOP_CODE) ? TOP_CODE : code;
  assign lvl     = taps[idx];
  assign lvl_nxt = taps_nxt[idx];
  assign pass    = (code == '0);
  assign stop    = (code == '1);
endmodule

// File: rtl/dclk_capture.sv
module dclk_capture (
  input  logic clk,
  input  logic rst,
  input  logic rise_sel,
  input  logic vid_pass,
  input  logic vid_stop,
  input  logic vid_lvl,
  input  logic vid_nxt,
  input  logic hs_in,
  input  logic vs_in,
  input  logic bl_in,
  output logic hs_q,
  output logic vs_q,
  output logic bl_q
);
  logic goes_up;
  logic goes_dn;
  logic take;

  assign goes_up = ~vid_lvl & vid_nxt;
  assign goes_dn = vid_lvl & ~vid_nxt;
  assign take    = ~vid_stop & (vid_pass | (rise_sel ? goes_up : goes_dn));

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      bl_q <= 1'b0;
    end else if (take) begin
      hs_q <= hs_in;
      vs_q <= vs_in;
      bl_q <= bl_in;
    end
  end
endmodule

// File: rtl/dclk_divider.sv
module dclk_divider #(
  parameter int LOG_MAX = dclk_pkg::LOG_MAX,
  parameter int CODE_W  = $clog2(LOG_MAX + 2),
  parameter int SEL_W   = 2 * CODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_din,
  input  logic             vclk_rise,
  input  logic             blank_in,
  input  logic             hsync_in,
  input  logic             vsync_in,
  output logic             ref_clk,
  output logic             shift_clk,
  output logic             vid_clk,
  output logic             hsync_q,
  output logic             vsync_q,
  output logic             blank_q
);
  localparam logic [SEL_W-1:0] SEL_RST = {{CODE_W{1'b1}}, {CODE_W{1'b0}}};

  logic [SEL_W-1:0]   sel_q;
  logic [LOG_MAX-1:0] cnt_q;
  logic [LOG_MAX-1:0] cnt_nxt;
  logic               reload;
  logic               gate_q;
  logic ref_lvl, ref_nxt, ref_pass, ref_stop;
  logic vid_lvl, vid_nxt, vid_pass, vid_stop;

  assign reload = sel_wr && (sel_din == '1);

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= SEL_RST;
    else if (sel_wr) sel_q <= sel_din;
  end

  dclk_counter #(.W(LOG_MAX)) u_cnt (
    .clk(clk), .rst(rst), .reload(reload), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
  );

  dclk_tap #(.LOG_MAX(LOG_MAX), .CODE_W(CODE_W)) u_ref_tap (
    .clk(clk), .code(sel_q[CODE_W-1:0]), .cnt(cnt_q), .cnt_nxt(cnt_nxt),
    .lvl(ref_lvl), .lvl_nxt(ref_nxt), .pass(ref_pass), .stop(ref_stop)
  );

  dclk_tap #(.LOG_MAX(LOG_MAX), .CODE_W(CODE_W)) u_vid_tap (
    .clk(clk), .code(sel_q[SEL_W-1:CODE_W]), .cnt(cnt_q), .cnt_nxt(cnt_nxt),
    .lvl(vid_lvl), .lvl_nxt(vid_nxt), .pass(vid_pass), .stop(vid_stop)
  );

  // Gate moves only where the reference clock is about to sit low.
  always_ff @(posedge clk) begin
    if (rst)                      gate_q <= 1'b0;
    else if (ref_pass || !ref_nxt) gate_q <= ~blank_in;
  end

  assign ref_clk   = ref_lvl;
  assign shift_clk = ~ref_stop & ref_lvl & gate_q;
  assign vid_clk   = vid_stop | vid_lvl;

  dclk_capture u_cap (
    .clk(clk), .rst(rst), .rise_sel(vclk_rise),
    .vid_pass(vid_pass), .vid_stop(vid_stop), .vid_lvl(vid_lvl), .vid_nxt(vid_nxt),
    .hs_in(hsync_in), .vs_in(vsync_in), .bl_in(blank_in),
    .hs_q(hsync_q), .vs_q(vsync_q), .bl_q(blank_q)
  );
endmodule

// File: rtl/dclk_divider_chk.sv
module dclk_divider_chk #(
  parameter int LOG_MAX = dclk_pkg::LOG_MAX,
  parameter int CODE_W  = dclk_pkg::CODE_W,
  parameter int SEL_W   = 2 * CODE_W
) (
  input logic               clk,
  input logic               rst,
  input logic               sel_wr,
  input logic [SEL_W-1:0]   sel_din,
  input logic [SEL_W-1:0]   sel,
  input logic [LOG_MAX-1:0] cnt,
  input logic               ref_clk,
  input logic               shift_clk,
  input logic               vid_clk,
  input logic               hsync_q,
  input logic               vsync_q,
  input logic               blank_q
);
  localparam logic [SEL_W-1:0] SEL_RST = {{CODE_W{1'b1}}, {CODE_W{1'b0}}};

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !(sel_wr && sel_din == '1) |=> cnt == $past(cnt) + LOG_MAX'(1));

  // R8
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_wr && sel_din == '1) |=> cnt == '1);

  // R4
  shift_in_ref_chk: assert property (@(posedge clk) disable iff (rst)
    shift_clk |-> ref_clk);

  // R5
  shift_off_chk: assert property (@(posedge clk) disable iff (rst)
    (sel[CODE_W-1:0] == '1) |-> !shift_clk);

  // R6
  vid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sel[SEL_W-1:CODE_W] == '1) |-> vid_clk);

  // R7
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sel[SEL_W-1:CODE_W] == '1) |=> $stable({hsync_q, vsync_q, blank_q}));

  // R9
  rst_state_chk: assert property (@(posedge clk)
    rst |=> (cnt == '1 && sel == SEL_RST && !hsync_q && !vsync_q && !blank_q));
endmodule

bind dclk_divider dclk_divider_chk #(.LOG_MAX(LOG_MAX), .CODE_W(CODE_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .sel_wr(sel_wr), .sel_din(sel_din), .sel(sel_q), .cnt(cnt_q),
  .ref_clk(ref_clk), .shift_clk(shift_clk), .vid_clk(vid_clk),
  .hsync_q(hsync_q), .vsync_q(vsync_q), .blank_q(blank_q)
);

// File: tb/dclk_divider_bench.sv
module dclk_divider_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1, sel_wr = 1'b0, vclk_rise = 1'b0;
  logic       blank_in = 1'b0, hsync_in = 1'b0, vsync_in = 1'b0;
  logic [5:0] sel_din = 6'h00;
  wire ref_clk, shift_clk, vid_clk, hsync_q, vsync_q, blank_q;

  dclk_divider u_dclk_divider (
    .clk(clk), .rst(rst), .sel_wr(sel_wr), .sel_din(sel_din), .vclk_rise(vclk_rise),
    .blank_in(blank_in), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .ref_clk(ref_clk), .shift_clk(shift_clk), .vid_clk(vid_clk),
    .hsync_q(hsync_q), .vsync_q(vsync_q), .blank_q(blank_q)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [5:0] m_cnt = 6'h3F, m_sel = 6'h38;
  bit m_gate = 0, m_hs = 0, m_vs = 0, m_bl = 0;
  bit s_ref, s_shift, s_vid;

  function automatic bit tap(int code, logic [5:0] c, bit ph);
    if (code == 0) return ph;
    return ~c[code-1];
  endfunction

  function automatic int rcode(logic [5:0] s);
    return (s[2:0] == 3'd7) ? 6 : int'(s[2:0]);
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_int(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(bit ph);
    int r = rcode(m_sel);
    int v = int'(m_sel[5:3]);
    bit e_ref = tap(r, m_cnt, ph);
    bit e_sh  = (m_sel[2:0] == 3'd7) ? 1'b0 : (e_ref & m_gate);
    bit e_vid = (v == 7) ? 1'b1 : tap(v, m_cnt, ph);
    chk("R2", "ref_clk", ref_clk, e_ref);
    chk("R4", "shift_clk", shift_clk, e_sh);
    chk("R6", "vid_clk", vid_clk, e_vid);
    chk("R7", "hsync_q", hsync_q, m_hs);
    chk("R7", "vsync_q", vsync_q, m_vs);
    chk("R7", "blank_q", blank_q, m_bl);
    if (!ph) begin
      s_ref = ref_clk; s_shift = shift_clk; s_vid = vid_clk;
    end
  endtask

  task automatic model_edge();
    logic [5:0] nxt;
    int r, v;
    bit cap, now_l, nxt_l;
    if (rst) begin
      m_cnt = 6'h3F; m_sel = 6'h38; m_gate = 0; m_hs = 0; m_vs = 0; m_bl = 0;
      return;
    end
    nxt = m_cnt + 6'd1;
    r = rcode(m_sel);
    v = int'(m_sel[5:3]);
    if (r == 0 || !tap(r, nxt, 1'b0)) m_gate = !blank_in;
    if (v == 7) cap = 0;
    else if (v == 0) cap = 1;
    else begin
      now_l = tap(v, m_cnt, 1'b0);
      nxt_l = tap(v, nxt, 1'b0);
      cap = vclk_rise ? (!now_l && nxt_l) : (now_l && !nxt_l);
    end
    if (cap) begin m_hs = hsync_in; m_vs = vsync_in; m_bl = blank_in; end
    m_cnt = (sel_wr && sel_din == 6'h3F) ? 6'h3F : nxt;
    if (sel_wr) m_sel = sel_din;
  endtask

  task automatic step(bit r, bit w, logic [5:0] d, bit b);
    @(negedge clk);
    rst = r; sel_wr = w; sel_din = d; blank_in = b;
    hsync_in = 1'($urandom);
    vsync_in = 1'($urandom);
    if ($urandom % 50 == 0) vclk_rise = ~vclk_rise;
    #1 compare(1'b0);
    @(posedge clk);
    model_edge();
    #1 compare(1'b1);
  endtask

  task automatic run_count(int n, bit b, output int ref_r, output int vid_r, output int sh_hi);
    bit pr, pv;
    for (int i = 0; i < 8; i++) step(0, 0, 6'h00, b);
    pr = s_ref; pv = s_vid;
    ref_r = 0; vid_r = 0; sh_hi = 0;
    for (int i = 0; i < n; i++) begin
      step(0, 0, 6'h00, b);
      if (s_ref && !pr) ref_r++;
      if (s_vid && !pv) vid_r++;
      if (s_shift) sh_hi++;
      pr = s_ref; pv = s_vid;
    end
  endtask

  initial begin
    int rr, vr, sh;
    bit b;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) step(1, 0, 6'h00, 0);
    step(0, 0, 6'h00, 0);
    // R9 reset state: video clock parked high, captures cleared
    chk("R9", "vid_clk after reset", vid_clk, 1'b1);
    chk("R9", "hsync_q after reset", hsync_q, 1'b0);

    // R8 reload: divided outputs low, then all rise on the next edge
    step(0, 1, 6'h3F, 0);
    chk("R8", "ref_clk right after reload", ref_clk, 1'b0);
    step(0, 1, 6'h12, 0);
    chk("R8", "ref_clk first rise", ref_clk, 1'b1);
    chk("R8", "vid_clk first rise", vid_clk, 1'b1);

    // R1 ratio codes: ref /8, vid /2
    step(0, 1, 6'h0B, 0);
    run_count(64, 0, rr, vr, sh);
    chk_int("R1", "ref rises over 64 edges", rr, 8);
    chk_int("R1", "vid rises over 64 edges", vr, 32);

    // R3 / R4 blanking: ref keeps running, shift silent
    run_count(64, 1, rr, vr, sh);
    chk_int("R3", "ref rises while blanked", rr, 8);
    chk_int("R4", "shift high samples while blanked", sh, 0);

    // R5 shift off; ref code 7 runs /64 (R3)
    step(0, 1, 6'h07, 0);
    run_count(64, 0, rr, vr, sh);
    chk_int("R5", "shift high samples when off", sh, 0);
    chk_int("R3", "ref rises at code 7", rr, 1);

    // R6 video clock held high
    step(0, 1, 6'h3A, 0);
    run_count(64, 0, rr, vr, sh);
    chk_int("R6", "vid rises when held", vr, 0);
    chk("R6", "vid level when held", vid_clk, 1'b1);

    // Random traffic, R7 capture polarity included
    b = 0;
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] d;
      if ($urandom % 20 == 0) b = ~b;
      d = ($urandom % 6 == 0) ? 6'h3F : 6'($urandom);
      step(($urandom % 500) == 0, ($urandom % 12) == 0, d, b);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule